// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator machine. It combines the working register W with a second operand and produces a byte result in the same cycle. The second operand is either a byte read from the register file or an immediate literal. A destination output tells the surrounding core whether the result goes back to W or to the file register.

Three status flags are held in a small register inside the block: carry, half carry (carry between the two nibbles) and zero. Each operation rewrites only its own set of flags. The others keep their value. The flag register loads on a rising clock edge while `flag_en` is high.

Subtraction takes W away from the second operand. Both rotates pass through the carry input.

Top module: `byte_alu`

## Requirements
- R1: Code 0 (add) gives result = (W + operand) mod 256, C = carry out of bit 7, DC = carry out of bit 3, Z = (result == 0); all three flags are written.
- R2: Code 1 (subtract) gives result = (operand − W) mod 256, C = 1 when operand ≥ W (no borrow), DC = 1 when operand[3:0] ≥ W[3:0], Z = (result == 0); all three flags are written.
- R3: Codes 2 (AND), 3 (inclusive OR) and 4 (XOR) combine W with the operand bitwise and write only Z; C and DC keep their value.
- R4: Codes 5 (complement), 6 (increment mod 256), 7 (decrement mod 256) and 8 (move, result = operand) write only Z.
- R5: Codes 9 (clear file) and 10 (clear W) give result 0 and set Z, leaving C and DC unchanged; code 9 always selects the file destination and code 10 always selects W.
- R6: Code 11 (rotate left) gives {operand[6:0], carry_in} and C = operand[7]; code 12 (rotate right) gives {carry_in, operand[7:1]} and C = operand[0]; Z and DC keep their value.
- R7: Code 13 (nibble swap) gives {operand[3:0], operand[7:4]} and changes no flag.
- R8: Except for codes 9 and 10, `dest_f` is 0 (W) when `use_lit` is 1; otherwise it equals `dest_bit` (0 = W, 1 = file).
- R9: Reset clears C, DC and Z to 0; while `flag_en` is 0 no flag changes.
- R10: Codes 14 and 15 are unused: result = W and no flag changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| flag_en | input | 1 | Lets the flag register load this cycle |
| op | input | 4 | Operation code |
| use_lit | input | 1 | 1 selects the literal as operand, 0 the file byte |
| dest_bit | input | 1 | Destination field of register-form operations |
| carry_in | input | 1 | Carry fed into the rotates |
| w_in | input | 8 | Working register value |
| f_in | input | 8 | File register value |
| lit_in | input | 8 | Immediate literal |
| result | output | 8 | Operation result |
| dest_f | output | 1 | 1 = write result to file register, 0 = to W |
| flag_c | output | 1 | Registered carry / no-borrow flag |
| flag_dc | output | 1 | Registered half-carry flag |
| flag_z | output | 1 | Registered zero flag |

## Verification
`result` and `dest_f` are combinational, so they are due in the same cycle as the inputs. The bench drives the inputs on the falling edge and checks these two outputs a short time later, before the next rising edge. The flags pass through one register and are due just after the first rising edge that follows the stimulus. The bench samples them shortly after that edge and compares them with a flag model it updates at the same point.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;
  parameter int DATA_W = 8;
  localparam int NIB_W = DATA_W / 2;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_SUB  = 4'd1,  OP_AND  = 4'd2,  OP_IOR = 4'd3,
    OP_XOR  = 4'd4,  OP_COM  = 4'd5,  OP_INC  = 4'd6,  OP_DEC = 4'd7,
    OP_MOV  = 4'd8,  OP_CLRF = 4'd9,  OP_CLRW = 4'd10, OP_RLC = 4'd11,
    OP_RRC  = 4'd12, OP_SWAP = 4'd13, OP_RSV0 = 4'd14, OP_RSV1 = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic dc;
    logic z;
  } flags_t;

  // Full-width add with carry in; top bit is the carry out.
  function automatic logic [DATA_W:0] add_full(input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b,
                                               input logic ci);
    return {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, ci};
  endfunction

  // Carry out of the low nibble for the same addition.
  function automatic logic nib_carry(input logic [DATA_W-1:0] a,
                                     input logic [DATA_W-1:0] b,
                                     input logic ci);
    logic [NIB_W:0] s;
    s = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, ci};
    return s[NIB_W];
  endfunction
endpackage

// File: rtl/alu_core.sv
`timescale 1ns/1ps
module alu_core
  import alu_pkg::*;
(
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] w,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output flags_t            nxt,
  output flags_t            wr
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W:0] add_s, sub_s;
  logic            add_h, sub_h;

  assign add_s = add_full(w, b, 1'b0);
  assign sub_s = add_full(b, ~w, 1'b1);
  assign add_h = nib_carry(w, b, 1'b0);
  assign sub_h = nib_carry(b, ~w, 1'b1);

  always_comb begin
    res    = w;
    nxt.c  = 1'b0;
    nxt.dc = 1'b0;
    wr     = '0;
    case (op)
      OP_ADD: begin
        res = add_s[DATA_W-1:0]; nxt.c = add_s[DATA_W]; nxt.dc = add_h;
        wr = '{c: 1'b1, dc: 1'b1, z: 1'b1};
      end
      OP_SUB: begin
        res = sub_s[DATA_W-1:0]; nxt.c = sub_s[DATA_W]; nxt.dc = sub_h;
        wr = '{c: 1'b1, dc: 1'b1, z: 1'b1};
      end
      OP_AND:  begin res = w & b;     wr.z = 1'b1; end
      OP_IOR:  begin res = w | b;     wr.z = 1'b1; end
      OP_XOR:  begin res = w ^ b;     wr.z = 1'b1; end
      OP_COM:  begin res = ~b;        wr.z = 1'b1; end
      OP_INC:  begin res = b + ONE;   wr.z = 1'b1; end
      OP_DEC:  begin res = b - ONE;   wr.z = 1'b1; end
      OP_MOV:  begin res = b;         wr.z = 1'b1; end
      OP_CLRF, OP_CLRW: begin res = '0; wr.z = 1'b1; end
      OP_RLC:  begin res = {b[DATA_W-2:0], cin}; nxt.c = b[DATA_W-1]; wr.c = 1'b1; end
      OP_RRC:  begin res = {cin, b[DATA_W-1:1]}; nxt.c = b[0];        wr.c = 1'b1; end
      OP_SWAP: res = {b[NIB_W-1:0], b[DATA_W-1:NIB_W]};
      default: res = w;
    endcase
    nxt.z = (res == '0);
  end
endmodule

// File: rtl/alu_flag_reg.sv
`timescale 1ns/1ps
module alu_flag_reg
  import alu_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  flags_t nxt,
  input  flags_t wr,
  output flags_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (en) begin
      if (wr.c)  q.c  <= nxt.c;
      if (wr.dc) q.dc <= nxt.dc;
      if (wr.z)  q.z  <= nxt.z;
    end
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> q == $past(q)); // R9
  AST_UNMASKED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wr.dc) |=> q.dc == $past(q.dc)); // R3
endmodule

// File: rtl/byte_alu.sv
`timescale 1ns/1ps
module byte_alu
  import alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_en,
  input  logic [3:0]        op,
  input  logic              use_lit,
  input  logic              dest_bit,
  input  logic              carry_in,
  input  logic [DATA_W-1:0] w_in,
  input  logic [DATA_W-1:0] f_in,
  input  logic [DATA_W-1:0] lit_in,
  output logic [DATA_W-1:0] result,
  output logic              dest_f,
  output logic              flag_c,
  output logic              flag_dc,
  output logic              flag_z
);
  alu_op_e           op_e;
  logic [DATA_W-1:0] operand;
  flags_t            flag_nxt, flag_wr, flag_q;
  logic              is_clear, is_logic, is_rotate;

  assign op_e      = alu_op_e'(op);
  assign operand   = use_lit ? lit_in : f_in;
  assign is_clear  = (op_e == OP_CLRF) || (op_e == OP_CLRW);
  assign is_logic  = (op_e == OP_AND) || (op_e == OP_IOR) || (op_e == OP_XOR);
  assign is_rotate = (op_e == OP_RLC) || (op_e == OP_RRC);

  alu_core u_core (
    .op (op_e), .w (w_in), .b (operand), .cin (carry_in),
    .res(result), .nxt(flag_nxt), .wr(flag_wr)
  );

  alu_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .en(flag_en),
    .nxt(flag_nxt), .wr(flag_wr), .q(flag_q)
  );

  always_comb begin
    if (op_e == OP_CLRF)      dest_f = 1'b1;
    else if (op_e == OP_CLRW) dest_f = 1'b0;
    else                      dest_f = use_lit ? 1'b0 : dest_bit;
  end

  assign flag_c  = flag_q.c;
  assign flag_dc = flag_q.dc;
  assign flag_z  = flag_q.z;

  AST_LIT_WRITES_W: assert property (@(posedge clk) disable iff (!rst_n)
    (use_lit && !is_clear) |-> !dest_f); // R8
  AST_CLEAR_SETS_Z: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && is_clear) |=> flag_z); // R5
  AST_LOGIC_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && is_logic) |=> $stable(flag_c) && $stable(flag_dc)); // R3
  AST_ROTATE_KEEPS_Z: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && is_rotate) |=> $stable(flag_z) && $stable(flag_dc)); // R6
  AST_SWAP_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_SWAP) |=> $stable({flag_c, flag_dc, flag_z})); // R7
  AST_RSV_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_RSV0 || op_e == OP_RSV1) |=> $stable({flag_c, flag_dc, flag_z})); // R10
endmodule

// File: tb/sim_byte_alu.sv
`timescale 1ns/1ps
module sim_byte_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flag_en = 1'b0;
  logic [3:0] op = 4'd0;
  logic       use_lit = 1'b0, dest_bit = 1'b0, carry_in = 1'b0;
  logic [7:0] w_in = 8'd0, f_in = 8'd0, lit_in = 8'd0;
  logic [7:0] result;
  logic       dest_f, flag_c, flag_dc, flag_z;

  int checks = 0;
  int errors = 0;
  bit m_c = 0, m_dc = 0, m_z = 0;

  always #10 clk = ~clk;

  byte_alu u0 (
    .clk(clk), .rst_n(rst_n), .flag_en(flag_en), .op(op), .use_lit(use_lit),
    .dest_bit(dest_bit), .carry_in(carry_in), .w_in(w_in), .f_in(f_in),
    .lit_in(lit_in), .result(result), .dest_f(dest_f), .flag_c(flag_c),
    .flag_dc(flag_dc), .flag_z(flag_z)
  );

  function automatic string tag(input int code);
    case (code)
      0: return "R1";  1: return "R2";
      2, 3, 4: return "R3";
      5, 6, 7, 8: return "R4";
      9, 10: return "R5";
      11, 12: return "R6";
      13: return "R7";
      default: return "R10";
    endcase
  endfunction

  // Reference: returns result and which flags are written, from the requirements.
  task automatic model(input int code, input int w, input int b, input bit ci,
                       output int r, output bit c, output bit dc,
                       output bit wc, output bit wdc, output bit wz);
    c = 0; dc = 0; wc = 0; wdc = 0; wz = 1; r = w;
    case (code)
      0: begin r = (w + b) % 256; c = (w + b) > 255; dc = (w % 16 + b % 16) > 15; wc = 1; wdc = 1; end
      1: begin r = (b - w + 256) % 256; c = b >= w; dc = (b % 16) >= (w % 16); wc = 1; wdc = 1; end
      2: r = w & b;
      3: r = w | b;
      4: r = w ^ b;
      5: r = 255 - b;
      6: r = (b + 1) % 256;
      7: r = (b + 255) % 256;
      8: r = b;
      9, 10: r = 0;
      11: begin r = (b * 2) % 256 + ci; c = b >= 128; wc = 1; wz = 0; end
      12: begin r = b / 2 + (ci ? 128 : 0); c = b % 2; wc = 1; wz = 0; end
      13: begin r = (b % 16) * 16 + b / 16; wz = 0; end
      default: begin r = w; wz = 0; end
    endcase
  endtask

  task automatic run_one(input int code, input int w, input int b, input bit ci,
                         input bit lit, input bit db, input bit en);
    int r; bit c, dc, wc, wdc, wz; bit exp_d;
    @(negedge clk);
    op = code[3:0]; w_in = w[7:0]; carry_in = ci; use_lit = lit; dest_bit = db;
    flag_en = en;
    if (lit) begin lit_in = b[7:0]; f_in = 8'($urandom); end
    else     begin f_in = b[7:0];   lit_in = 8'($urandom); end
    model(code, w, b, ci, r, c, dc, wc, wdc, wz);
    exp_d = (code == 9) ? 1'b1 : (code == 10) ? 1'b0 : (lit ? 1'b0 : db);
    #3;
    checks++;
    if (result !== r[7:0]) begin
      errors++;
      $display("FAIL %s op=%0d w=%h b=%h: result %h expected %h", tag(code), code, w, b, result, r[7:0]);
    end
    checks++;
    if (dest_f !== exp_d) begin
      errors++;
      $display("FAIL R8 op=%0d lit=%0b d=%0b: dest_f %0b expected %0b", code, lit, db, dest_f, exp_d);
    end
    @(posedge clk);
    if (en) begin
      if (wc)  m_c  = c;
      if (wdc) m_dc = dc;
      if (wz)  m_z  = (r == 0);
    end
    #3;
    checks++;
    if ({flag_c, flag_dc, flag_z} !== {m_c, m_dc, m_z}) begin
      errors++;
      $display("FAIL %s/R9 op=%0d w=%h b=%h en=%0b: flags %b expected %b", tag(code), code, w, b, en,
               {flag_c, flag_dc, flag_z}, {m_c, m_dc, m_z});
    end
  endtask

  initial begin
    int wset[9];
    void'($urandom(32'd20240611));
    wset[0] = 8'h00; wset[1] = 8'h01; wset[2] = 8'h0F; wset[3] = 8'h80; wset[4] = 8'hFF;
    for (int i = 5; i < 9; i++) wset[i] = $urandom % 256;
    repeat (3) @(posedge clk);
    #3;
    checks++;
    if ({flag_c, flag_dc, flag_z} !== 3'b000) begin
      errors++;
      $display("FAIL R9 reset flags %b expected 000", {flag_c, flag_dc, flag_z});
    end
    @(negedge clk);
    rst_n = 1'b1;
    // Directed corners: borrow boundaries and clear behaviour.
    run_one(1, 8'h10, 8'h10, 0, 0, 1, 1);   // R2 equal: C=1, Z=1
    run_one(1, 8'h01, 8'h00, 0, 1, 1, 1);   // R2 borrow: C=0, DC=0
    run_one(0, 8'h08, 8'h08, 0, 0, 0, 1);   // R1 half carry
    run_one(9, 8'h55, 8'h12, 0, 1, 0, 1);   // R5 clear-file goes to file
    run_one(13, 8'h00, 8'hA5, 1, 0, 1, 1);  // R7 swap keeps flags
    run_one(2, 8'h0F, 8'hF0, 0, 0, 0, 0);   // R9 disabled flag update
    // Sweep: every code, a set of W values, both carry-in states, all operands.
    for (int code = 0; code < 16; code++)
      for (int wi = 0; wi < 9; wi++)
        for (int ci = 0; ci < 2; ci++)
          for (int b = 0; b < 256; b++)
            run_one(code, wset[wi], b, ci[0], 1'($urandom), 1'($urandom), ($urandom % 8) != 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule